// File: doc/BRIEF.md
# Predicated In-Place Tree-Reduction Scheduler

This block produces the operand-index schedule for a predicated tree reduction over a vector of up to 16 elements. It never moves data. A start pulse latches a vector length and a lane mask. The block then walks the reduction tree layer by layer and emits one pair of register indices per accepted transfer. The first index names the first operand, and it is also where the combined value is written back. The second index names the second operand. An external arithmetic unit and register file carry out each operation.

When a tree node has only its upper lane live, the partial result in that lane stays in its register. The scheduler records that position and uses it as the operand index in later layers. Lanes whose mask bit is clear, and lanes at or beyond the vector length, take no part. After the last pair is accepted, a one-cycle done pulse appears with the index of the register that holds the final result. The schedule depends only on the vector length and the mask, so restarting with the same inputs produces the same sequence.

Top module: `tree_red_seq`

## Requirements
- R1: After reset, `pair_valid`, `done` and `busy` are all 0.
- R2: The pair size starts at 2 and doubles on each layer. The last layer is the one whose pair size reaches or exceeds the vector length. Within a layer, lower slot i (a multiple of the pair size) is paired with slot i plus half the pair size, and slots are visited in ascending order.
- R3: `op_a` names the first operand and is the write-back destination. `op_b` names the second operand. If the write-back `reg[op_a] = reg[op_a] + reg[op_b]` is applied for every accepted pair, `reg[result_idx]` ends up holding the sum of all participating lanes.
- R4: When only the upper slot of a pair is live, its recorded position is carried into the lower slot without any output. Later layers use that position as the operand index.
- R5: A mask with exactly one participating lane produces no pairs, then a done pulse with `result_idx` equal to that lane.
- R6: A mask with no participating lane produces no pairs, then a done pulse.
- R7: A vector length of 0 or 1 produces no pairs, then a done pulse.
- R8: A pair is consumed only in a cycle where `pair_valid` and `pair_ready` are both high. While the output is stalled, `pair_valid`, `op_a` and `op_b` hold steady.
- R9: A `start` pulse while `busy` is high is ignored. The running schedule continues unchanged.
- R10: `done` is high for exactly one cycle, after the last pair is accepted. `pair_valid` is low during that cycle, and `result_idx` is valid during it.
- R11: Two runs with the same vector length and mask produce identical pair sequences and the same result index.
- R12: Mask bits at positions at or above the vector length are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a schedule. Only accepted when idle |
| vec_len | input | 5 | Vector length, from 0 to 16 |
| lane_mask | input | 16 | Lane predicate. Bit k enables lane k |
| pair_valid | output | 1 | A pair is presented |
| pair_ready | input | 1 | The consumer accepts the presented pair |
| op_a | output | 4 | First operand index and write-back destination |
| op_b | output | 4 | Second operand index |
| done | output | 1 | One-cycle end-of-schedule pulse |
| result_idx | output | 4 | Register holding the final value, valid with `done` |
| busy | output | 1 | A schedule is in progress |

## Verification
A full mask over the full length checks the plain power-of-two tree. Sparse and irregular masks make lower slots go empty, so they show whether surviving positions are remembered and reused rather than reset to their own lane. Non-power-of-two lengths with mask bits set beyond the length separate correct layer termination and window clipping from off-by-one behaviour. Single-lane, empty and short-length inputs check the degenerate paths. Repeated runs, a throttled consumer and a mid-run start pulse check re-entrancy, stall stability and the start guard. Every run is replayed through a register-file write-back model and compared with a software reduction.

// File: rtl/tree_red_pkg.sv
package tree_red_pkg;

    localparam int LANES = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } tr_state_e;

endpackage

// File: rtl/tree_red_walker.sv
// Walks (layer, lower slot) through the reduction tree.
module tree_red_walker #(
    parameter int N  = tree_red_pkg::LANES,
    localparam int IW  = $clog2(N),
    localparam int VLW = $clog2(N + 1),
    localparam int LW  = (IW > 1) ? $clog2(IW) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [VLW-1:0] vl_in,
    input  logic           adv,
    output logic [IW-1:0]  pos,
    output logic [IW-1:0]  half,
    output logic           last
);
    localparam int WW = IW + 2;

    logic [LW-1:0]  lvl_q;
    logic [IW-1:0]  pos_q;
    logic [VLW-1:0] vl_q;
    logic [WW-1:0]  nxt_lo, nxt_hi, vl_w, span;
    logic           layer_end, top_layer;

    assign half = IW'(1) << lvl_q;
    assign pos  = pos_q;

    always_comb begin
        nxt_lo    = {2'b00, pos_q} + {1'b0, half, 1'b0};
        nxt_hi    = nxt_lo + {2'b00, half};
        vl_w      = WW'(vl_q);
        span      = {1'b0, half, 1'b0};
        layer_end = (nxt_hi >= vl_w);
        top_layer = (span >= vl_w);
        last      = layer_end && top_layer;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            pos_q <= '0;
            vl_q  <= '0;
        end else if (load) begin
            lvl_q <= '0;
            pos_q <= '0;
            vl_q  <= vl_in;
        end else if (adv) begin
            if (layer_end) begin
                lvl_q <= lvl_q + LW'(1);
                pos_q <= '0;
            end else begin
                pos_q <= nxt_lo[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/tree_red_lanes.sv
// Per-lane live flags and remembered positions of partial results.
module tree_red_lanes #(
    parameter int N  = tree_red_pkg::LANES,
    localparam int IW  = $clog2(N),
    localparam int VLW = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [VLW-1:0] vl_in,
    input  logic [N-1:0]   mask_in,
    input  logic           upd,
    input  logic [IW-1:0]  pos,
    input  logic [IW-1:0]  half,
    output logic           lo_live,
    output logic           hi_live,
    output logic [IW-1:0]  lo_idx,
    output logic [IW-1:0]  hi_idx,
    output logic [IW-1:0]  root_idx
);
    logic [N-1:0]  live_q;
    logic [IW-1:0] where_q [N];
    logic [IW-1:0] hi_pos;

    assign hi_pos   = pos + half;
    assign lo_live  = live_q[pos];
    assign hi_live  = live_q[hi_pos];
    assign lo_idx   = where_q[pos];
    assign hi_idx   = where_q[hi_pos];
    assign root_idx = where_q[0];

    for (genvar k = 0; k < N; k++) begin : g_lane
        localparam logic [VLW-1:0] KV = VLW'(k);
        localparam logic [IW-1:0]  KI = IW'(k);
        logic pull;
        assign pull = upd && !lo_live && hi_live && (pos == KI);

        always_ff @(posedge clk) begin
            if (rst) begin
                live_q[k]  <= 1'b0;
                where_q[k] <= KI;
            end else if (load) begin
                live_q[k]  <= mask_in[k] && (KV < vl_in);
                where_q[k] <= KI;
            end else if (pull) begin
                live_q[k]  <= 1'b1;
                where_q[k] <= hi_idx;
            end
        end
    end
endmodule

// File: rtl/tree_red_seq.sv
module tree_red_seq #(
    parameter int N  = tree_red_pkg::LANES,
    localparam int IW  = $clog2(N),
    localparam int VLW = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [VLW-1:0] vec_len,
    input  logic [N-1:0]   lane_mask,
    output logic           pair_valid,
    input  logic           pair_ready,
    output logic [IW-1:0]  op_a,
    output logic [IW-1:0]  op_b,
    output logic           done,
    output logic [IW-1:0]  result_idx,
    output logic           busy
);
    import tree_red_pkg::*;

    tr_state_e     st_q;
    logic          load, adv, emit, last;
    logic          lo_live, hi_live;
    logic [IW-1:0] pos, half, lo_idx, hi_idx, root_idx;

    assign load = (st_q == ST_IDLE) && start;
    assign emit = (st_q == ST_RUN) && lo_live && hi_live;
    assign adv  = (st_q == ST_RUN) && (!emit || pair_ready);

    tree_red_walker #(.N(N)) u_walk (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .vl_in (vec_len),
        .adv   (adv),
        .pos   (pos),
        .half  (half),
        .last  (last)
    );

    tree_red_lanes #(.N(N)) u_lanes (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .vl_in    (vec_len),
        .mask_in  (lane_mask),
        .upd      (adv),
        .pos      (pos),
        .half     (half),
        .lo_live  (lo_live),
        .hi_live  (hi_live),
        .lo_idx   (lo_idx),
        .hi_idx   (hi_idx),
        .root_idx (root_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) st_q <= (vec_len <= VLW'(1)) ? ST_FIN : ST_RUN;
                ST_RUN:  if (adv && last) st_q <= ST_FIN;
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign pair_valid = emit;
    assign op_a       = lo_idx;
    assign op_b       = hi_idx;
    assign done       = (st_q == ST_FIN);
    assign result_idx = root_idx;
    assign busy       = (st_q != ST_IDLE);
endmodule

// File: rtl/tree_red_seq_chk.sv
module tree_red_seq_chk #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          pair_valid,
    input logic          pair_ready,
    input logic [IW-1:0] op_a,
    input logic [IW-1:0] op_b,
    input logic          done,
    input logic          busy
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        pair_valid && !pair_ready |=> pair_valid && $stable(op_a) && $stable(op_b)); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_NO_PAIR: assert property (@(posedge clk) disable iff (rst)
        done |-> !pair_valid); // R10
    AST_PAIR_ORDERED: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> (op_a < op_b)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !pair_valid && !done); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy && !done && start |=> busy); // R9
endmodule

bind tree_red_seq tree_red_seq_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pair_valid (pair_valid),
    .pair_ready (pair_ready),
    .op_a       (op_a),
    .op_b       (op_b),
    .done       (done),
    .busy       (busy)
);

// File: tb/tree_red_seq_test.sv
module tree_red_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  vec_len = '0;
    logic [15:0] lane_mask = '0;
    logic        pair_ready = 1'b1;
    logic        pair_valid, done, busy;
    logic [3:0]  op_a, op_b, result_idx;

    int checks = 0;
    int errors = 0;

    int exp_a [16];
    int exp_b [16];
    int exp_n, exp_root, exp_live;
    int got_a [16];
    int got_b [16];
    int got_n, got_root;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tree_red_seq uut (
        .clk(clk), .rst(rst), .start(start), .vec_len(vec_len),
        .lane_mask(lane_mask), .pair_valid(pair_valid), .pair_ready(pair_ready),
        .op_a(op_a), .op_b(op_b), .done(done), .result_idx(result_idx), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Software reduction schedule from the requirements.
    task automatic build_model(input int vl, input logic [15:0] m);
        bit live [16];
        int pos_of [16];
        exp_n = 0;
        exp_live = 0;
        for (int k = 0; k < 16; k++) begin
            live[k] = m[k] && (k < vl);
            pos_of[k] = k;
            if (live[k]) exp_live++;
        end
        for (int h = 1; h < vl; h = h * 2) begin
            for (int i = 0; i + h < vl; i = i + 2 * h) begin
                if (live[i] && live[i + h]) begin
                    exp_a[exp_n] = pos_of[i];
                    exp_b[exp_n] = pos_of[i + h];
                    exp_n++;
                end else if (live[i + h]) begin
                    pos_of[i] = pos_of[i + h];
                    live[i] = 1'b1;
                end
            end
        end
        exp_root = pos_of[0];
    endtask

    task automatic run_case(input string tag, input int vl, input logic [15:0] m,
                            input bit throttle, input bit poke);
        int cyc = 0;
        bit stalled = 0;
        int pa = 0, pb = 0;
        int regs [16];
        int want_sum = 0;
        build_model(vl, m);
        for (int k = 0; k < 16; k++) begin
            regs[k] = k * k + 3;
            if (m[k] && k < vl) want_sum += regs[k];
        end
        got_n = 0;
        got_root = -1;
        @(negedge clk);
        vec_len = 5'(vl);
        lane_mask = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (stalled) begin
                check(pair_valid && op_a == 4'(pa) && op_b == 4'(pb),
                      {tag, " R8 stall hold"}, {28'd0, op_a}, pa);
            end
            if (done) begin
                got_root = result_idx;
                check(!pair_valid, {tag, " R10 no pair with done"}, pair_valid, 0);
                break;
            end
            if (poke && cyc == 2) begin
                vec_len = 5'd2;
                lane_mask = 16'h0003;
                start = 1'b1;
            end else begin
                start = 1'b0;
                vec_len = 5'(vl);
                lane_mask = m;
            end
            pair_ready = throttle ? ((cyc % 3) != 1) : 1'b1;
            stalled = pair_valid && !pair_ready;
            pa = op_a;
            pb = op_b;
            if (pair_valid && pair_ready) begin
                if (got_n < 16) begin
                    got_a[got_n] = op_a;
                    got_b[got_n] = op_b;
                end
                got_n++;
                regs[op_a] = regs[op_a] + regs[op_b];
            end
            cyc++;
            if (cyc > 400) begin
                check(0, {tag, " watchdog"}, cyc, 400);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        pair_ready = 1'b1;
        check(got_n == exp_n, {tag, " pair count"}, got_n, exp_n);
        for (int j = 0; j < exp_n && j < got_n && j < 16; j++) begin
            check(got_a[j] == exp_a[j], {tag, " op_a"}, got_a[j], exp_a[j]);
            check(got_b[j] == exp_b[j], {tag, " op_b"}, got_b[j], exp_b[j]);
        end
        if (exp_live > 0) begin
            check(got_root == exp_root, {tag, " R10 result_idx"}, got_root, exp_root);
            if (got_root >= 0)
                check(regs[got_root] == want_sum, {tag, " R3 write-back sum"},
                      regs[got_root], want_sum);
        end
        @(negedge clk);
        check(!done, {tag, " R10 done single cycle"}, done, 0);
        check(!busy, {tag, " back to idle"}, busy, 0);
    endtask

    task automatic t_reset;
        check(!pair_valid && !done && !busy, "R1 reset state",
              {pair_valid, done, busy}, 0);
    endtask

    task automatic t_full;
        run_case("R2 full16", 16, 16'hFFFF, 0, 0);
        run_case("R2 full8", 8, 16'h00FF, 0, 0);
    endtask

    task automatic t_sparse;
        run_case("R4 sparse A5C3", 16, 16'hA5C3, 0, 0);
        run_case("R4 sparse 8001", 16, 16'h8001, 0, 0);
        run_case("R4 sparse 6660", 13, 16'h6660, 0, 0);
    endtask

    task automatic t_window;
        run_case("R12 vl6 all mask", 6, 16'hFFFF, 0, 0);
        run_case("R12 vl11", 11, 16'hFFFF, 0, 0);
        run_case("R12 lane above vl", 8, 16'h8000, 0, 0);
        check(got_n == 0, "R12 no pairs beyond window", got_n, 0);
    endtask

    task automatic t_single;
        run_case("R5 single", 16, 16'h0400, 0, 0);
        check(got_n == 0, "R5 no pairs", got_n, 0);
        check(got_root == 10, "R5 result lane", got_root, 10);
    endtask

    task automatic t_empty;
        run_case("R6 empty", 16, 16'h0000, 0, 0);
        check(got_n == 0, "R6 no pairs", got_n, 0);
    endtask

    task automatic t_short;
        run_case("R7 vl0", 0, 16'hFFFF, 0, 0);
        check(got_n == 0, "R7 vl0 no pairs", got_n, 0);
        run_case("R7 vl1", 1, 16'hFFFF, 0, 0);
        check(got_n == 0, "R7 vl1 no pairs", got_n, 0);
    endtask

    task automatic t_stall;
        run_case("R8 throttled", 16, 16'hFFFF, 1, 0);
        run_case("R8 throttled sparse", 15, 16'h5B3D, 1, 0);
    endtask

    task automatic t_poke;
        run_case("R9 start while busy", 16, 16'hFFFF, 0, 1);
    endtask

    task automatic t_repeat;
        int first_a [16];
        int first_b [16];
        int first_n, first_root;
        run_case("R11 first", 14, 16'h3CF5, 0, 0);
        first_n = got_n;
        first_root = got_root;
        for (int j = 0; j < 16; j++) begin
            first_a[j] = got_a[j];
            first_b[j] = got_b[j];
        end
        run_case("R11 second", 14, 16'h3CF5, 0, 0);
        check(got_n == first_n, "R11 same count", got_n, first_n);
        check(got_root == first_root, "R11 same result", got_root, first_root);
        for (int j = 0; j < first_n && j < 16; j++)
            check(got_a[j] == first_a[j] && got_b[j] == first_b[j], "R11 same pair",
                  got_a[j] * 16 + got_b[j], first_a[j] * 16 + first_b[j]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full();
        t_sparse();
        t_window();
        t_single();
        t_empty();
        t_short();
        t_stall();
        t_poke();
        t_repeat();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule